// File: doc/BRIEF.md
# 66-bit block boundary lock

This block receives a serial bit stream made of back-to-back 66-bit line blocks whose start position is unknown. Every block opens with a two-bit header and then carries 64 scrambled payload bits. At the true boundary the two header bits always differ. At any other position the scrambled payload makes equal bits likely. The block tests a candidate boundary one block at a time. When it sees a bad header it moves the candidate one bit later, until it has seen enough good headers in a row to declare lock.

Once locked, the block keeps watching header quality over fixed windows of blocks. It drops lock only when too many bad headers fall inside one window, and then resumes the search one bit further on. Every completed block is presented in parallel with a one-cycle strobe and a header classification. Downstream logic can then decode payloads only while the lock flag is high.

Top module: `blk_lock`

## Requirements
- R1: The first accepted bit of a block lands in `block_o[65]` and the last in `block_o[0]`, so the header is `block_o[65:64]`. `blk_vld_o` pulses for one cycle per 66 accepted bits, and two pulses are never closer than 66 cycles.
- R2: `hdr_type_o` reports 1 for header `01` (data) and 2 for header `10` (control).
- R3: Headers `00` and `11` are reported as type 0 (invalid) and are never reported as data or control.
- R4: While unlocked, an invalid header raises `slip_o` for one cycle together with that block's strobe. The next block then starts one accepted bit later than it otherwise would, and the good-header run count restarts.
- R5: `lock_o` rises together with the strobe of the 64th consecutive valid-header block at one offset. Data and control headers both count.
- R6: While locked, invalid headers are reported but lock is kept as long as fewer than 16 fall in one window. Windows are 64 blocks long, the first begins with the block after the locking block, and each window starts its count from zero.
- R7: The 16th invalid header inside one window makes `lock_o` fall and `slip_o` pulse with that block's strobe, and the search resumes.
- R8: Input bits presented while `bit_vld_i` is low are ignored: they are neither shifted in nor counted.
- R9: Reset clears lock, slip, strobe, header type, the counters and the candidate offset. The first block after reset is built from the first 66 accepted bits.
- R10: Starting from an arbitrary bit offset in a valid stream, the block reaches lock and then delivers the transmitted blocks unchanged and in order.
- R11: `lock_o` and `hdr_type_o` change only in cycles where `blk_vld_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Serial line bit |
| bit_vld_i | input | 1 | `bit_i` carries a line bit this cycle |
| block_o | output | 66 | Block at the current candidate boundary, header in bits 65:64 |
| blk_vld_o | output | 1 | One-cycle strobe for `block_o` |
| hdr_type_o | output | 2 | 0 invalid, 1 data, 2 control |
| lock_o | output | 1 | Boundary locked |
| slip_o | output | 1 | Candidate boundary moved by one bit |

## Verification
The assertions assume that `bit_vld_i` and `bit_i` are never unknown out of reset, and that at most one bit enters per cycle. That limit is what bounds the strobe spacing. The stimulus drives both inputs from a known value from time zero, and it inserts idle cycles that carry an inverted bit, so any bit that leaked in would corrupt the aligned blocks. Payloads come from a 64-bit xorshift generator, which makes false headers at wrong offsets appear quickly. Invalid headers are placed only at chosen positions of an already aligned stream, so the expected lock and slip cycles can be computed exactly.

// File: rtl/blk_lock_pkg.sv
package blk_lock_pkg;
  localparam int BLK_W = 66;
  localparam int HDR_W = 2;

  typedef enum logic [1:0] {
    HDR_BAD  = 2'd0,
    HDR_DATA = 2'd1,
    HDR_CTRL = 2'd2
  } hdr_type_e;
endpackage

// File: rtl/blk_aligner.sv
module blk_aligner
  import blk_lock_pkg::*;
#(
  parameter int BW = BLK_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bit_i,
  input  logic          bit_vld_i,
  input  logic          slip_i,
  output logic [BW-1:0] blk_o,
  output logic          stb_o
);
  localparam int CNT_W = $clog2(BW);

  logic [BW-2:0]    sreg_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pend_q;
  logic [BW-1:0]    word;

  assign word = {sreg_q, bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q <= '0;
      cnt_q  <= '0;
      pend_q <= 1'b0;
      blk_o  <= '0;
      stb_o  <= 1'b0;
    end else begin
      stb_o <= 1'b0;
      if (bit_vld_i) begin
        sreg_q <= word[BW-2:0];
        // a slip swallows one accepted bit from the count
        if (slip_i || pend_q) begin
          pend_q <= 1'b0;
        end else if (cnt_q == CNT_W'(BW-1)) begin
          cnt_q <= '0;
          blk_o <= word;
          stb_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else if (slip_i) begin
        pend_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/hdr_classify.sv
module hdr_classify
  import blk_lock_pkg::*;
(
  input  logic [HDR_W-1:0] hdr_i,
  output hdr_type_e        type_o
);
  always_comb begin
    unique case (hdr_i)
      2'b01:   type_o = HDR_DATA;
      2'b10:   type_o = HDR_CTRL;
      default: type_o = HDR_BAD;
    endcase
  end
endmodule

// File: rtl/lock_ctrl.sv
module lock_ctrl
  import blk_lock_pkg::*;
#(
  parameter int BW       = BLK_W,
  parameter int LOCK_CNT = 64,
  parameter int WIN_LEN  = 64,
  parameter int BAD_LIM  = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          stb_i,
  input  logic [BW-1:0] blk_i,
  input  hdr_type_e     type_i,
  output logic          slip_req_o,
  output logic [BW-1:0] block_o,
  output logic          blk_vld_o,
  output hdr_type_e     hdr_type_o,
  output logic          lock_o,
  output logic          slip_o
);
  localparam int GOOD_W = $clog2(LOCK_CNT + 1);
  localparam int WIN_W  = $clog2(WIN_LEN + 1);
  localparam int BAD_W  = $clog2(BAD_LIM + 1);

  typedef enum logic {ST_HUNT, ST_LOCK} st_e;

  st_e               st_q, st_d;
  logic [GOOD_W-1:0] good_q, good_d;
  logic [WIN_W-1:0]  win_q, win_d;
  logic [BAD_W-1:0]  badc_q, badc_d;
  logic              bad, last_bad;

  assign bad        = (type_i == HDR_BAD);
  assign last_bad   = (badc_q == BAD_W'(BAD_LIM - 1));
  assign slip_req_o = stb_i && bad && ((st_q == ST_HUNT) || last_bad);

  always_comb begin
    st_d   = st_q;
    good_d = good_q;
    win_d  = win_q;
    badc_d = badc_q;
    if (stb_i) begin
      case (st_q)
        ST_HUNT: begin
          if (bad) begin
            good_d = '0;
          end else if (good_q == GOOD_W'(LOCK_CNT - 1)) begin
            st_d   = ST_LOCK;
            good_d = '0;
            win_d  = '0;
            badc_d = '0;
          end else begin
            good_d = good_q + 1'b1;
          end
        end
        ST_LOCK: begin
          if (bad && last_bad) begin
            st_d   = ST_HUNT;
            win_d  = '0;
            badc_d = '0;
          end else if (win_q == WIN_W'(WIN_LEN - 1)) begin
            win_d  = '0;
            badc_d = '0;
          end else begin
            win_d = win_q + 1'b1;
            if (bad) badc_d = badc_q + 1'b1;
          end
        end
        default: st_d = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_HUNT;
      good_q     <= '0;
      win_q      <= '0;
      badc_q     <= '0;
      block_o    <= '0;
      blk_vld_o  <= 1'b0;
      hdr_type_o <= HDR_BAD;
      lock_o     <= 1'b0;
      slip_o     <= 1'b0;
    end else begin
      st_q      <= st_d;
      good_q    <= good_d;
      win_q     <= win_d;
      badc_q    <= badc_d;
      blk_vld_o <= stb_i;
      slip_o    <= slip_req_o;
      lock_o    <= (st_d == ST_LOCK);
      if (stb_i) begin
        block_o    <= blk_i;
        hdr_type_o <= type_i;
      end
    end
  end
endmodule

// File: rtl/blk_lock.sv
module blk_lock
  import blk_lock_pkg::*;
#(
  parameter int LOCK_CNT = 64,
  parameter int WIN_LEN  = 64,
  parameter int BAD_LIM  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_i,
  input  logic             bit_vld_i,
  output logic [BLK_W-1:0] block_o,
  output logic             blk_vld_o,
  output logic [1:0]       hdr_type_o,
  output logic             lock_o,
  output logic             slip_o
);
  logic [BLK_W-1:0] raw_blk;
  logic             raw_stb;
  logic             slip_req;
  hdr_type_e        raw_type;
  hdr_type_e        type_q;

  blk_aligner #(.BW(BLK_W)) u_align (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bit_i     (bit_i),
    .bit_vld_i (bit_vld_i),
    .slip_i    (slip_req),
    .blk_o     (raw_blk),
    .stb_o     (raw_stb)
  );

  hdr_classify u_cls (
    .hdr_i  (raw_blk[BLK_W-1 -: HDR_W]),
    .type_o (raw_type)
  );

  lock_ctrl #(
    .BW       (BLK_W),
    .LOCK_CNT (LOCK_CNT),
    .WIN_LEN  (WIN_LEN),
    .BAD_LIM  (BAD_LIM)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stb_i      (raw_stb),
    .blk_i      (raw_blk),
    .type_i     (raw_type),
    .slip_req_o (slip_req),
    .block_o    (block_o),
    .blk_vld_o  (blk_vld_o),
    .hdr_type_o (type_q),
    .lock_o     (lock_o),
    .slip_o     (slip_o)
  );

  assign hdr_type_o = type_q;
endmodule

// File: rtl/blk_lock_chk.sv
module blk_lock_chk #(
  parameter int BW = 66
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [BW-1:0] block_o,
  input logic          blk_vld_o,
  input logic [1:0]    hdr_type_o,
  input logic          lock_o,
  input logic          slip_o
);
  logic [6:0] gap_q;
  logic       seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (blk_vld_o) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else if (gap_q != 7'd127) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  AST_BLK_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk_vld_o && seen_q) |-> (gap_q >= 7'd65)); // R1

  AST_BAD_NEVER_ACCEPTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk_vld_o && (block_o[BW-1] == block_o[BW-2])) |-> (hdr_type_o == 2'd0)); // R3

  AST_SLIP_WITH_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slip_o |-> blk_vld_o); // R4

  AST_SLIP_ON_BAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slip_o |-> (hdr_type_o == 2'd0)); // R4

  AST_LOCK_RISE_GOOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> (blk_vld_o && hdr_type_o != 2'd0)); // R5

  AST_SLIP_UNLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slip_o |-> !lock_o); // R7

  AST_LOCK_FALL_SLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lock_o) |-> slip_o); // R7

  AST_LOCK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !blk_vld_o |-> ($stable(lock_o) && $stable(hdr_type_o))); // R11
endmodule

bind blk_lock blk_lock_chk #(.BW(66)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .block_o    (block_o),
  .blk_vld_o  (blk_vld_o),
  .hdr_type_o (hdr_type_o),
  .lock_o     (lock_o),
  .slip_o     (slip_o)
);

// File: tb/blk_lock_test.sv
module blk_lock_test;
  localparam int CLK_PERIOD = 10;
  localparam int BW = 66;
  localparam int NSEG = 10;
  // {hdr[1:0], blocks[7:0], lock, type[1:0], slip on last block}
  localparam logic [13:0] SEG_TBL [NSEG] = '{
    {2'b01, 8'd40, 1'b0, 2'd1, 1'b0},
    {2'b10, 8'd23, 1'b0, 2'd2, 1'b0},
    {2'b01, 8'd1,  1'b1, 2'd1, 1'b0},
    {2'b00, 8'd5,  1'b1, 2'd0, 1'b0},
    {2'b01, 8'd49, 1'b1, 2'd1, 1'b0},
    {2'b11, 8'd10, 1'b1, 2'd0, 1'b0},
    {2'b00, 8'd10, 1'b1, 2'd0, 1'b0},
    {2'b10, 8'd54, 1'b1, 2'd2, 1'b0},
    {2'b11, 8'd15, 1'b1, 2'd0, 1'b0},
    {2'b00, 8'd1,  1'b0, 2'd0, 1'b1}
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          bit_i = 1'b0;
  logic          bit_vld_i = 1'b0;
  logic [BW-1:0] block_o;
  logic          blk_vld_o;
  logic [1:0]    hdr_type_o;
  logic          lock_o;
  logic          slip_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  blk_lock uut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bit_i      (bit_i),
    .bit_vld_i  (bit_vld_i),
    .block_o    (block_o),
    .blk_vld_o  (blk_vld_o),
    .hdr_type_o (hdr_type_o),
    .lock_o     (lock_o),
    .slip_o     (slip_o)
  );

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [63:0]   rs = 64'h9E3779B97F4A7C15;
  logic [BW-1:0] exp_blk [256];
  logic [1:0]    exp_typ [256];
  logic          exp_lock [256];
  logic          exp_slip [256];
  int            exp_wr = 0;
  int            out_rd = 0;
  logic [BW-1:0] sent [512];
  int            n_sent = 0;
  int            mode = 0;
  bit            synced = 1'b0;
  int            idx = 0;
  int            matched = 0;
  bit            gap_en = 1'b0;
  int            bit_ctr = 0;
  logic          prev_lock = 1'b0;
  logic [1:0]    prev_typ = 2'd0;
  int            r11_bad = 0;

  task automatic chk(input bit ok, input string req, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic nxt(output logic [63:0] v);
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 7);
    rs = rs ^ (rs << 17);
    v = rs;
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk_i);
    if (gap_en && (bit_ctr % 7 == 6)) begin
      bit_vld_i = 1'b0;
      bit_i = ~b;   // must be ignored, R8
      @(negedge clk_i);
    end
    bit_i = b;
    bit_vld_i = 1'b1;
    bit_ctr++;
  endtask

  task automatic send_blk(input logic [BW-1:0] b);
    for (int i = BW - 1; i >= 0; i--) send_bit(b[i]);
  endtask

  task automatic idle(input int n);
    @(negedge clk_i);
    bit_vld_i = 1'b0;
    repeat (n) @(negedge clk_i);
  endtask

  task automatic push(input logic [BW-1:0] b, input logic [1:0] t, input logic l, input logic s);
    exp_blk[exp_wr] = b;
    exp_typ[exp_wr] = t;
    exp_lock[exp_wr] = l;
    exp_slip[exp_wr] = s;
    exp_wr++;
  endtask

  task automatic do_reset();
    mode = 0;
    @(negedge clk_i);
    rst_ni = 1'b0;
    bit_vld_i = 1'b0;
    repeat (3) @(negedge clk_i);
    exp_wr = 0;
    out_rd = 0;
    n_sent = 0;
    synced = 1'b0;
    matched = 0;
    bit_ctr = 0;
    rst_ni = 1'b1;
  endtask

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      prev_lock = 1'b0;
      prev_typ = 2'd0;
    end else begin
      if (!blk_vld_o && (lock_o !== prev_lock || hdr_type_o !== prev_typ)) r11_bad++;
      prev_lock = lock_o;
      prev_typ = hdr_type_o;
      if (blk_vld_o && mode == 1) begin
        if (out_rd < exp_wr) begin
          chk(block_o === exp_blk[out_rd], "R1 R8 block", block_o, exp_blk[out_rd]);
          chk(hdr_type_o === exp_typ[out_rd], "R2 R3 type", BW'(hdr_type_o), BW'(exp_typ[out_rd]));
          chk(lock_o === exp_lock[out_rd], "R5 R6 R7 lock", BW'(lock_o), BW'(exp_lock[out_rd]));
          chk(slip_o === exp_slip[out_rd], "R4 R7 slip", BW'(slip_o), BW'(exp_slip[out_rd]));
        end else begin
          chk(1'b0, "R1 unexpected block", block_o, '0);
        end
        out_rd++;
      end else if (blk_vld_o && mode == 2 && lock_o) begin
        if (!synced) begin
          for (int j = 0; j < n_sent; j++) begin
            if (!synced && sent[j] === block_o) begin
              synced = 1'b1;
              idx = j;
            end
          end
          chk(synced, "R10 first locked block", block_o, '0);
        end else begin
          idx++;
          if (idx < n_sent) begin
            chk(block_o === sent[idx], "R10 aligned block", block_o, sent[idx]);
            if (block_o === sent[idx]) matched++;
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog R1-timeout: actual hung expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0]   p;
    logic [BW-1:0] b;
    logic [BW-1:0] blk0;

    // reset state, R9
    repeat (2) @(negedge clk_i);
    chk({lock_o, slip_o, blk_vld_o, hdr_type_o} === 5'b0, "R9 reset outputs",
        BW'({lock_o, slip_o, blk_vld_o, hdr_type_o}), '0);

    // table walk: aligned stream with idle gaps, R2-R8
    do_reset();
    gap_en = 1'b1;
    mode = 1;
    for (int s = 0; s < NSEG; s++) begin
      for (int k = 0; k < int'(SEG_TBL[s][11:4]); k++) begin
        nxt(p);
        b = {SEG_TBL[s][13:12], p};
        push(b, SEG_TBL[s][2:1], SEG_TBL[s][3],
             SEG_TBL[s][0] && (k == int'(SEG_TBL[s][11:4]) - 1));
        send_blk(b);
      end
    end
    idle(8);
    chk(out_rd == exp_wr, "R6 R7 block count", BW'(out_rd), BW'(exp_wr));
    chk(lock_o == 1'b0, "R7 lock lost", BW'(lock_o), '0);

    // one-bit misalignment after reset: first block bad, then lock, R4 R5 R9
    do_reset();
    gap_en = 1'b0;
    mode = 1;
    nxt(p);
    blk0 = {2'b01, p};
    push({1'b0, blk0[BW-1:1]}, 2'd0, 1'b0, 1'b1);
    send_bit(1'b0);
    send_blk(blk0);
    for (int k = 1; k <= 64; k++) begin
      nxt(p);
      b = {(p[0] ? 2'b01 : 2'b10), p};
      push(b, (p[0] ? 2'd1 : 2'd2), (k == 64), 1'b0);
      send_blk(b);
    end
    idle(8);
    chk(out_rd == exp_wr, "R4 R5 block count", BW'(out_rd), BW'(exp_wr));
    chk(lock_o == 1'b1, "R5 locked", BW'(lock_o), BW'(1));

    // arbitrary offset acquisition with gaps, R10
    do_reset();
    gap_en = 1'b1;
    mode = 2;
    for (int i = 0; i < 13; i++) begin
      nxt(p);
      send_bit(p[5]);
    end
    for (int k = 0; k < 200; k++) begin
      nxt(p);
      b = {(p[3] ? 2'b10 : 2'b01), p};
      sent[n_sent] = b;
      n_sent++;
      send_blk(b);
    end
    idle(8);
    chk(synced && matched >= 50, "R10 relock", BW'(matched), BW'(50));
    chk(lock_o == 1'b1, "R10 lock held", BW'(lock_o), BW'(1));

    // reset while locked, R9
    mode = 0;
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk({lock_o, slip_o, blk_vld_o, hdr_type_o} === 5'b0, "R9 reset while locked",
        BW'({lock_o, slip_o, blk_vld_o, hdr_type_o}), '0);
    chk(block_o === '0, "R9 block cleared", block_o, '0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    chk(r11_bad == 0, "R11 changes off strobe", BW'(r11_bad), '0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule